// File: doc/BRIEF.md
# Soft-Decision Convolutional Decoder (Register-Exchange Viterbi)

This block recovers the information bits of a rate 1/N convolutional code, where N is 2 to 4 and the constraint length is 3 to 9. Each accepted input word holds N signed soft symbols, one for each coded bit of a single trellis step. For every accepted word, the block advances the trellis by one step. After a fixed fill period, it returns one decoded bit for each accepted word. The code generators, soft-symbol width, path-metric width and survivor depth are elaboration parameters.

Inside the block, a branch-metric stage correlates each soft symbol with every possible coded bit pattern. One add-compare-select unit per trellis state keeps the running path metrics, and these metrics are halved together whenever one of them grows into its top bit. The survivors are kept entirely in flip-flops using register exchange: each state carries its own decoded-bit history, and that history is rewritten on every step. The decoded bit is the oldest entry of the history of the state that currently has the largest metric.

Input and output use valid/ready handshakes. A word is consumed on a cycle where `in_valid` and `in_ready` are both high. A decoded bit is handed over on a cycle where `out_valid` and `out_ready` are both high. The output has a single register stage. `in_ready` is high whenever that stage is empty or is being drained in the same cycle. When the consumer holds `out_ready` low while a bit is waiting, the whole trellis stalls and the waiting bit stays unchanged.

Top module: `vit_decoder`

## Requirements
- R1: The encoder window is w = {newest bit, previous L-1 bits with the most recent at the higher position}. Coded bit i is the parity of w AND generator i. Symbol i sits in field i of `in_data`, counting from the most significant end. With clean symbols of magnitude 3, the decoded stream equals the encoded stream.
- R2: Symbols are two's complement. A value with the MSB set (negative) favours a coded 1, and a value with the MSB clear favours a coded 0. The branch metric adds the value when expecting 0 and subtracts it when expecting 1. Mixed magnitudes from 1 to 4, and isolated strongly wrong symbols, still decode correctly.
- R3: An all-zero symbol is an erasure. It adds the same amount to every branch, so it cannot change any decision. A stream that has every other second symbol erased decodes correctly.
- R4: An asynchronous active-high `rst` clears all path metrics, all survivors, the fill count, `out_valid` and `normalize`. After reset, `in_ready` is high.
- R5: When any updated path metric reaches 2^(PM_W-1), all updated metrics are halved in that same step. `normalize` is high for the one clock that follows that step.
- R6: While no word is accepted, the path metrics, the survivors and the fill count do not change, so idle gaps do not alter the decoded stream or the normalization instants.
- R7: Accepting word k (counting from 0) hands the output stage the decoded bit of word k-TB_DEPTH. `out_valid` first rises after the (TB_DEPTH+1)-th accepted word, and a run of n words yields n-TB_DEPTH decoded bits.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold.
- R9: In the add-compare-select, equal candidates go to the lower-numbered predecessor. In the best-state search, equal metrics go to the lower state index. A fully erased stream therefore decodes as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | A soft-symbol word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | N_SYM*SOFT_W | N soft symbols, the first symbol in the most significant field |
| out_valid | output | 1 | `out_bit` holds a decoded bit |
| out_ready | input | 1 | The consumer takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |
| normalize | output | 1 | One-clock pulse after a metric-halving step |

## Verification
The in-line assertions check the following on every cycle:
- no stored path metric ever keeps its top bit;
- metrics and survivors hold while no word is accepted;
- the newest survivor entry of each state matches that state's top bit;
- a normalize pulse only follows an accepted word;
- a stalled output holds;
- `out_valid` never rises before the fill count completes.

Only the bench scenarios can show that the trellis conventions, the symbol polarity, the handling of erasures and the tie rules produce the right bits. The same holds for the exact acceptance count at which the first bit appears and the exact steps at which halving occurs.

// File: rtl/vit_pkg.sv
package vit_pkg;

  // Pick generator i out of the four generator parameters.
  function automatic int gen_sel(input int i, input int g0, input int g1,
                                 input int g2, input int g3);
    case (i)
      0:       return g0;
      1:       return g1;
      2:       return g2;
      default: return g3;
    endcase
  endfunction

  // Coded-bit pattern produced by encoder window w.
  // Bit (n-1-i) of the result is the parity of generator i.
  function automatic int code_of(input int w, input int n, input int g0,
                                 input int g1, input int g2, input int g3);
    int h;
    h = 0;
    for (int i = 0; i < n; i++) begin
      int t;
      t = w & gen_sel(i, g0, g1, g2, g3);
      if (^t) h = h | (1 << (n - 1 - i));
    end
    return h;
  endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
  parameter int N_SYM  = 2,
  parameter int SOFT_W = 3,
  parameter int PM_W   = 10
) (
  input  logic [N_SYM*SOFT_W-1:0]      sym_vec,
  output logic [(1<<N_SYM)*PM_W-1:0]   bm_flat
);
  localparam int NH  = 1 << N_SYM;
  localparam int OFF = 1 << (SOFT_W - 1);

  // One correlator per coded-bit hypothesis. The offset keeps every term
  // non-negative, and an erased (zero) symbol yields OFF for every hypothesis.
  for (genvar h = 0; h < NH; h++) begin : g_hyp
    int acc;
    always_comb begin
      acc = 0;
      for (int i = 0; i < N_SYM; i++) begin
        logic signed [SOFT_W-1:0] v;
        v = sym_vec[(N_SYM-i)*SOFT_W-1 -: SOFT_W];
        if (((h >> (N_SYM - 1 - i)) & 1) == 1)
          acc = acc + OFF - int'(v);
        else
          acc = acc + OFF + int'(v);
      end
    end
    assign bm_flat[h*PM_W +: PM_W] = PM_W'(acc);
  end

endmodule

// File: rtl/vit_pmu.sv
module vit_pmu #(
  parameter int N_SYM = 2,
  parameter int L_K   = 5,
  parameter int PM_W  = 10,
  parameter int G0    = 19,
  parameter int G1    = 29,
  parameter int G2    = 0,
  parameter int G3    = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic [(1<<N_SYM)*PM_W-1:0]    bm_flat,
  output logic [(1<<(L_K-1))*PM_W-1:0]  pm_flat,
  output logic [(1<<(L_K-1))-1:0]       dec,
  output logic                          norm_pulse
);
  localparam int NS = 1 << (L_K - 1);

  logic [NS*PM_W-1:0] cand_flat;
  logic [NS*PM_W-1:0] nxt_flat;
  logic               hit;
  logic [NS-1:0]      msb_q;

  // Add-compare-select, one unit per next state ns.
  // The window is {ns, b}; the predecessors are (2*ns mod NS) + b.
  for (genvar ns = 0; ns < NS; ns++) begin : g_acs
    localparam int P0 = (ns * 2) % NS;
    localparam int P1 = P0 + 1;
    localparam int H0 = vit_pkg::code_of(ns * 2,     N_SYM, G0, G1, G2, G3);
    localparam int H1 = vit_pkg::code_of(ns * 2 + 1, N_SYM, G0, G1, G2, G3);
    logic [PM_W-1:0] c0, c1;
    assign c0 = pm_flat[P0*PM_W +: PM_W] + bm_flat[H0*PM_W +: PM_W];
    assign c1 = pm_flat[P1*PM_W +: PM_W] + bm_flat[H1*PM_W +: PM_W];
    assign dec[ns] = c1 > c0;          // ties keep the lower predecessor
    assign cand_flat[ns*PM_W +: PM_W] = dec[ns] ? c1 : c0;
  end

  always_comb begin
    hit = 1'b0;
    for (int s = 0; s < NS; s++) hit = hit | cand_flat[s*PM_W + PM_W - 1];
    for (int s = 0; s < NS; s++) begin
      if (hit)
        nxt_flat[s*PM_W +: PM_W] = {1'b0, cand_flat[s*PM_W + 1 +: PM_W - 1]};
      else
        nxt_flat[s*PM_W +: PM_W] = cand_flat[s*PM_W +: PM_W];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pm_flat    <= '0;
      norm_pulse <= 1'b0;
    end else begin
      norm_pulse <= adv && hit;
      if (adv) pm_flat <= nxt_flat;
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) msb_q[s] = pm_flat[s*PM_W + PM_W - 1];
  end

  // R5: after every update the stored metrics stay below the halving threshold
  a_r5_metrics_below_top: assert property (@(posedge clk) disable iff (rst)
    msb_q == '0);
  // R5: a halving pulse only follows an accepted step
  a_r5_pulse_after_step: assert property (@(posedge clk) disable iff (rst)
    norm_pulse |-> $past(adv));
  // R6: metrics hold while no word is accepted
  a_r6_metrics_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pm_flat));

endmodule

// File: rtl/vit_sre.sv
module vit_sre #(
  parameter int L_K = 5,
  parameter int TB  = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic [(1<<(L_K-1))-1:0]      dec,
  output logic [(1<<(L_K-1))*TB-1:0]   surv_flat
);
  localparam int NS = 1 << (L_K - 1);

  logic [NS*TB-1:0] nxt_flat;
  logic             armed;

  // Register exchange: each state copies its chosen predecessor's history,
  // shifts it by one, and appends the bit that led into the state (its top bit).
  for (genvar ns = 0; ns < NS; ns++) begin : g_ex
    localparam int   P0     = (ns * 2) % NS;
    localparam int   P1     = P0 + 1;
    localparam logic NEWEST = ((ns >> (L_K - 2)) & 1) != 0;
    assign nxt_flat[ns*TB +: TB] = dec[ns]
      ? {surv_flat[P1*TB +: TB-1], NEWEST}
      : {surv_flat[P0*TB +: TB-1], NEWEST};

    // R1: after a step, the newest history entry equals the state's top bit
    a_r1_newest_entry: assert property (@(posedge clk) disable iff (rst)
      armed && $past(adv) |-> surv_flat[ns*TB] == NEWEST);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      surv_flat <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (adv) surv_flat <= nxt_flat;
    end
  end

  // R6: histories hold while no word is accepted
  a_r6_survivors_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(surv_flat));

endmodule

// File: rtl/vit_decoder.sv
module vit_decoder #(
  parameter int N_SYM    = 2,
  parameter int L_K      = 5,
  parameter int SOFT_W   = 3,
  parameter int PM_W     = 10,
  parameter int TB_DEPTH = 24,
  parameter int G0       = 19,
  parameter int G1       = 29,
  parameter int G2       = 0,
  parameter int G3       = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_SYM*SOFT_W-1:0]   in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_bit,
  output logic                      normalize
);
  localparam int NS    = 1 << (L_K - 1);
  localparam int NH    = 1 << N_SYM;
  localparam int SEL_W = L_K - 1;
  localparam int CNT_W = $clog2(TB_DEPTH + 1);

  logic                 adv;
  logic [NH*PM_W-1:0]   bm_flat;
  logic [NS*PM_W-1:0]   pm_flat;
  logic [NS-1:0]        dec;
  logic [NS*TB_DEPTH-1:0] surv_flat;
  logic [SEL_W-1:0]     best_idx;
  logic [PM_W-1:0]      best_val;
  logic                 oldest_bit;
  logic [CNT_W-1:0]     fill_cnt;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  vit_bmu #(.N_SYM(N_SYM), .SOFT_W(SOFT_W), .PM_W(PM_W)) u_bmu (
    .sym_vec (in_data),
    .bm_flat (bm_flat)
  );

  vit_pmu #(.N_SYM(N_SYM), .L_K(L_K), .PM_W(PM_W),
            .G0(G0), .G1(G1), .G2(G2), .G3(G3)) u_pmu (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .bm_flat    (bm_flat),
    .pm_flat    (pm_flat),
    .dec        (dec),
    .norm_pulse (normalize)
  );

  vit_sre #(.L_K(L_K), .TB(TB_DEPTH)) u_sre (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .dec       (dec),
    .surv_flat (surv_flat)
  );

  // Best state among the stored metrics; equal values keep the lower index.
  always_comb begin
    best_idx = '0;
    best_val = pm_flat[0 +: PM_W];
    for (int s = 1; s < NS; s++) begin
      if (pm_flat[s*PM_W +: PM_W] > best_val) begin
        best_val = pm_flat[s*PM_W +: PM_W];
        best_idx = SEL_W'(s);
      end
    end
  end

  assign oldest_bit = surv_flat[int'(best_idx)*TB_DEPTH + TB_DEPTH - 1];

  // The fill count and a single output register with a valid/ready handover.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (adv && fill_cnt != CNT_W'(TB_DEPTH)) fill_cnt <= fill_cnt + 1'b1;
      if (adv) begin
        out_valid <= (fill_cnt == CNT_W'(TB_DEPTH));
        out_bit   <= oldest_bit;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: a waiting bit is held until it is taken
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));
  // R7: no decoded bit before the histories are full
  a_r7_fill_before_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fill_cnt == CNT_W'(TB_DEPTH));

endmodule

// File: tb/test_vit_decoder.sv
module test_vit_decoder;
  localparam int N    = 2;
  localparam int S    = 3;
  localparam int L    = 5;
  localparam int W    = 10;
  localparam int TB   = 24;
  localparam int GA   = 19;
  localparam int GB   = 29;
  localparam int IN_W = N * S;
  localparam int OFF  = 1 << (S - 1);
  localparam int STEP = N * (OFF + 3);   // best-path gain per clean step, magnitude 3
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic            in_valid;
  logic            in_ready;
  logic [IN_W-1:0] in_data;
  logic            out_valid;
  logic            out_ready;
  logic            out_bit;
  logic            normalize;

  vit_decoder #(.N_SYM(N), .L_K(L), .SOFT_W(S), .PM_W(W), .TB_DEPTH(TB),
                .G0(GA), .G1(GB), .G2(0), .G3(0)) i_vit_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .normalize(normalize)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [IN_W-1:0] vq [512];
  logic            uq [512];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [S-1:0] mk_sym(input logic c, input int mag);
    int v;
    v = c ? -mag : mag;
    return v[S-1:0];
  endfunction

  // mode 0 clean, 1 erasures, 2 isolated errors, 3 mixed magnitudes, 4 all erased
  task automatic make_stream(input int n, input int mode);
    logic [L-2:0] st;
    logic [10:0]  lf;
    st = '0;
    lf = 11'h5A3;
    for (int k = 0; k < n; k++) begin
      logic [L-1:0]    w;
      logic [IN_W-1:0] vec;
      logic            u;
      lf = {lf[9:0], lf[10] ^ lf[8]};
      u  = (mode == 4) ? 1'b0 : lf[0];
      w  = {u, st};
      for (int i = 0; i < N; i++) begin
        int         g;
        logic       c;
        logic [S-1:0] sy;
        g  = (i == 0) ? GA : GB;
        c  = ^(w & g[L-1:0]);
        sy = mk_sym(c, 3);
        if (mode == 1 && (k % 2) == 1 && i == 1) sy = '0;
        if (mode == 2 && (k % 29) == 7 && i == (k % 2)) sy = mk_sym(!c, 3);
        if (mode == 3) sy = c ? mk_sym(1'b1, (k + i) % 4 + 1) : mk_sym(1'b0, (k + i) % 3 + 1);
        if (mode == 4) sy = '0;
        vec[(N-i)*S-1 -: S] = sy;
      end
      vq[k] = vec;
      uq[k] = u;
      st = w[L-1:1];
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_stream(input int n, input int gap_mod, input int rdy_mod,
                            input bit chk_norm, input string rq);
    int   idx, ocnt, cyc, mx, drain, nnorm;
    bit   pend, hold, hbit, seen;
    logic v, r, acc;
    idx = 0; ocnt = 0; cyc = 0; mx = 0; drain = 0; nnorm = 0;
    pend = 0; hold = 0; hbit = 0; seen = 0;
    while (idx < n || drain < 2) begin
      if (idx >= n) drain++;
      v = (idx < n) && !(gap_mod > 0 && (cyc % gap_mod) == gap_mod - 1);
      r = (idx >= n) || !(rdy_mod > 0 && (cyc % rdy_mod) == rdy_mod - 1);
      in_valid = v; in_data = v ? vq[idx] : '0; out_ready = r;
      #1;
      chk(in_ready == (!out_valid || r), "R8 ready rule", in_ready, !out_valid || r);
      if (hold) chk(out_valid && out_bit == hbit, "R8 held bit", out_bit, hbit);
      hold = out_valid && !r;
      hbit = out_bit;
      if (chk_norm) begin
        chk(normalize == pend, "R5 normalize instant", normalize, pend);
        if (pend) nnorm++;
      end
      if (out_valid && !seen) begin
        seen = 1;
        chk(idx == TB + 1, "R7 first output latency", idx, TB + 1);
      end
      if (out_valid && r) begin
        chk(out_bit == uq[ocnt], {rq, " decoded bit"}, out_bit, uq[ocnt]);
        ocnt++;
      end
      acc  = v && in_ready;
      pend = 0;
      if (acc && chk_norm) begin
        mx = mx + STEP;
        if (mx >= HALF) begin mx = mx / 2; pend = 1; end
      end
      if (acc) idx++;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    chk(ocnt == n - TB, "R7 output count", ocnt, n - TB);
    if (chk_norm) chk(nnorm >= 1, "R5 halving seen", nnorm, 1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == 1'b0, "R4 out_valid after reset", out_valid, 0);
    chk(normalize == 1'b0, "R4 normalize after reset", normalize, 0);
    chk(in_ready == 1'b1, "R4 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_clean();      // R1, R5, R7
    do_reset(); make_stream(120, 0); run_stream(120, 0, 0, 1, "R1");
  endtask

  task automatic t_erasures();   // R3
    do_reset(); make_stream(100, 1); run_stream(100, 0, 0, 0, "R3");
  endtask

  task automatic t_polarity();   // R2
    do_reset(); make_stream(100, 3); run_stream(100, 0, 0, 0, "R2 magnitudes");
    do_reset(); make_stream(100, 2); run_stream(100, 0, 0, 0, "R2 errors");
  endtask

  task automatic t_all_erased(); // R9
    do_reset(); make_stream(60, 4); run_stream(60, 0, 0, 0, "R9");
  endtask

  task automatic t_stall();      // R6
    do_reset(); make_stream(120, 0); run_stream(120, 4, 0, 1, "R6");
  endtask

  task automatic t_backpressure(); // R8
    do_reset(); make_stream(90, 0); run_stream(90, 0, 3, 0, "R8");
  endtask

  task automatic t_reset_mid();  // R4
    do_reset(); make_stream(40, 0); run_stream(40, 0, 0, 0, "R4 pre");
    #3 rst = 1'b1;
    #2;
    chk(out_valid == 1'b0, "R4 async clear of out_valid", out_valid, 0);
    @(negedge clk); rst = 1'b0; @(negedge clk);
    make_stream(80, 0); run_stream(80, 0, 0, 1, "R4 restart");
  endtask

  initial begin
    #(20 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    t_reset_state();
    t_clean();
    t_erasures();
    t_polarity();
    t_all_erased();
    t_stall();
    t_backpressure();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule